// File: doc/BRIEF.md
# SPI Memory Transaction Engine

This block is an SPI master that carries register and memory accesses to a peripheral with a 22-bit byte address space. A request names an operation, an address, a byte count and up to four bytes of write data. The engine pulls chip-select low and sends a short address header. It then moves the data bytes and releases chip-select. Read data comes back either assembled into a 32-bit word or, in burst mode, one byte at a time on a valid-qualified output. Burst writes take their bytes from a ready/valid input stream. A third operation sends a fixed three-byte command frame with no address or data phase.

Values of up to four bytes travel least-significant byte first, in both directions. The bits inside each byte travel most-significant bit first. The serial clock rate comes from a divider input, so the same engine can run a slow bring-up phase and a fast operating phase. Between two frames, chip-select stays high for at least one serial clock period.

Top module: `spi_mem_engine`

## Requirements
- R1: The serial link runs in mode 0. SCK is low whenever chip-select is high. MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge. Each byte is shifted most-significant bit first.
- R2: SCK stays high for `clk_div`+1 clock cycles per pulse and low for at least that long. The rate is taken from the `clk_div` value present while a frame runs.
- R3: A write (`req_op`=2'b01) starts with three header bytes, in this order: {1'b1, 1'b0, addr[21:16]}, addr[15:8], addr[7:0].
- R4: A read (`req_op`=2'b00) sends the same three address bytes with bit 7 of the first byte clear. It then sends one 8'h00 filler byte. While read data is received, MOSI carries 8'h00.
- R5: A non-burst write of `req_len` bytes (1 to 4) sends `req_wdata` byte 0 (bits 7:0) first, then the higher bytes in order.
- R6: A non-burst read of `req_len` bytes (1 to 4) stores data byte j in `rd_data[8j+7:8j]`. Bytes that are not read are zero when `done` pulses.
- R7: A host command (`req_op`=2'b10) is exactly three bytes: `req_wdata[7:0]`, 8'h00, 8'h00. It has no data phase.
- R8: A burst write (`req_burst`=1) sends `req_len` data bytes taken in order from the `tx_data` stream after one header. While no byte is offered, SCK stays low and chip-select stays low.
- R9: A burst read delivers each of its `req_len` data bytes once on `rx_data`, with a one-cycle `rx_valid` pulse, in the order received.
- R10: Chip-select stays low from the first header bit to the last data bit. `done` is a single-cycle pulse in the first cycle after chip-select has risen again.
- R11: After each frame, chip-select stays high for at least 2*(`clk_div`+1) cycles. `req_ready` is high only while the engine is idle with chip-select high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_div | input | 8 | SCK half-period minus one, in clock cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle; the request is taken in this cycle |
| req_op | input | 2 | 00 read, 01 write, 10 host command |
| req_addr | input | 22 | Byte address |
| req_len | input | 8 | Data byte count |
| req_burst | input | 1 | Move data through the byte streams |
| req_wdata | input | 32 | Write data, or the command byte in bits 7:0 |
| rd_data | output | 32 | Assembled read data |
| done | output | 1 | Frame finished pulse |
| tx_valid | input | 1 | Burst write byte offered |
| tx_ready | output | 1 | Engine takes the offered byte |
| tx_data | input | 8 | Burst write byte |
| rx_valid | output | 1 | Burst read byte pulse |
| rx_data | output | 8 | Burst read byte |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |
| spi_cs_n | output | 1 | Chip-select, active low |

## Verification
A behavioural peripheral model records every MOSI byte and answers with random bytes. This lets header, filler and data bytes be compared position by position for each operation. Directed frames use the all-ones address and the zero address, which expose a misplaced write flag or a reversed address byte order. Reads of one, two and four bytes separate correct little-endian assembly from byte reversal and from stale upper bytes. Burst writes with random stalls show whether the engine waits or sends garbage, and random mixes of operation, length and divider catch timing that depends on the rate. Frames issued back-to-back at one divider test the minimum chip-select gap.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_WR   = 2'b01,
    OP_HCMD = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP
  } st_e;

  localparam logic [7:0] WR_FLAG = 8'h80;

  // number of bytes that come before the data phase
  function automatic logic [2:0] hdr_bytes(op_e op);
    return (op == OP_WR || op == OP_HCMD) ? 3'd3 : 3'd4;
  endfunction

  // header byte k of a frame (k counts from the first byte on the wire)
  function automatic logic [7:0] hdr_byte(op_e op, logic [23:0] a,
                                          logic [7:0] cmd, logic [1:0] k);
    logic [7:0] b;
    if (op == OP_HCMD) begin
      b = (k == 2'd0) ? cmd : 8'h00;
    end else begin
      case (k)
        2'd0:    b = a[23:16] | ((op == OP_WR) ? WR_FLAG : 8'h00);
        2'd1:    b = a[15:8];
        2'd2:    b = a[7:0];
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic [DIV_W-1:0] tmr;
  logic [3:0]       ph;
  logic [7:0]       txs;
  logic [7:0]       rxs;
  logic             act;
  logic             edge_now;

  assign edge_now = act && (tmr == div);
  assign mosi     = txs[7];
  assign rx_byte  = rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      ph   <= '0;
      txs  <= '0;
      rxs  <= '0;
      act  <= 1'b0;
      sck  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !act) begin
        act <= 1'b1;
        txs <= tx_byte;
        tmr <= '0;
        ph  <= '0;
        sck <= 1'b0;
      end else if (act) begin
        if (edge_now) begin
          tmr <= '0;
          ph  <= ph + 4'd1;
          if (!ph[0]) begin
            sck <= 1'b1;
            rxs <= {rxs[6:0], miso};
          end else begin
            sck <= 1'b0;
            txs <= {txs[6:0], 1'b0};
            if (ph == 4'd15) begin
              act  <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_eng_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_burst,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              byte_start,
  output logic [7:0]        byte_tx,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic              cs_n
);
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int IDX_W  = LEN_W + 2;
  localparam int GAP_W  = DIV_W + 1;

  st_e               st;
  op_e               op_q;
  op_e               in_op;
  logic [23:0]       addr_q;
  logic              burst_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  total_q;
  logic [IDX_W-1:0]  didx;
  logic [2:0]        hdr_q;
  logic [GAP_W-1:0]  gap_cnt;
  logic [GAP_W-1:0]  gap_lim;
  logic              in_data;
  logic              is_rd;
  logic              need_stream;
  logic              last;

  function automatic logic [7:0] pick_lane(logic [DATA_W-1:0] w, logic [LANE_W-1:0] i);
    return w[8*i +: 8];
  endfunction

  assign in_op       = op_e'(req_op);
  assign in_data     = idx >= IDX_W'(hdr_q);
  assign didx        = idx - IDX_W'(hdr_q);
  assign is_rd       = (op_q == OP_RD) || (op_q == OP_RSVD);
  assign need_stream = burst_q && (op_q == OP_WR) && in_data;
  assign last        = (idx == total_q - 1'b1);
  assign gap_lim     = {clk_div, 1'b1};

  assign req_ready  = (st == ST_IDLE);
  assign cs_n       = (st == ST_IDLE) || (st == ST_GAP);
  assign tx_ready   = (st == ST_LOAD) && need_stream;
  assign byte_start = (st == ST_LOAD) && (!need_stream || tx_valid);

  always_comb begin
    if (!in_data)
      byte_tx = hdr_byte(op_q, addr_q, wdata_q[7:0], idx[1:0]);
    else if (op_q == OP_WR)
      byte_tx = need_stream ? tx_data : pick_lane(wdata_q, didx[LANE_W-1:0]);
    else
      byte_tx = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op_q     <= OP_RD;
      addr_q   <= '0;
      burst_q  <= 1'b0;
      wdata_q  <= '0;
      idx      <= '0;
      total_q  <= '0;
      hdr_q    <= '0;
      gap_cnt  <= '0;
      rd_data  <= '0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          op_q    <= in_op;
          addr_q  <= 24'(req_addr);
          burst_q <= req_burst;
          wdata_q <= req_wdata;
          hdr_q   <= hdr_bytes(in_op);
          total_q <= (in_op == OP_HCMD) ? IDX_W'(3)
                   : IDX_W'(hdr_bytes(in_op)) + IDX_W'(req_len);
          idx     <= '0;
          rd_data <= '0;
          st      <= ST_LOAD;
        end
        ST_LOAD: if (byte_start) st <= ST_SHIFT;
        ST_SHIFT: if (byte_done) begin
          if (in_data && is_rd) begin
            if (burst_q) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_byte;
            end else begin
              for (int b = 0; b < NB; b++)
                if (didx == IDX_W'(b)) rd_data[8*b +: 8] <= rx_byte;
            end
          end
          if (last) begin
            done    <= 1'b1;
            gap_cnt <= '0;
            st      <= ST_GAP;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_LOAD;
          end
        end
        ST_GAP: begin
          if (gap_cnt == gap_lim) st <= ST_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
  parameter int ADDR_W = 22,
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_burst,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  // internal events, named for the checker
  logic       byte_start;
  logic       byte_done;
  logic [7:0] byte_tx;
  logic [7:0] rx_byte;

  spi_frame_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DIV_W(DIV_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_div    (clk_div),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_burst  (req_burst),
    .req_wdata  (req_wdata),
    .rd_data    (rd_data),
    .done       (done),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .byte_start (byte_start),
    .byte_tx    (byte_tx),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .cs_n       (spi_cs_n)
  );

  spi_bit_engine #(.DIV_W(DIV_W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (byte_start),
    .tx_byte (byte_tx),
    .div     (clk_div),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (byte_done),
    .rx_byte (rx_byte)
  );
endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] clk_div,
  input logic             spi_cs_n,
  input logic             spi_sck,
  input logic             spi_mosi,
  input logic             req_ready,
  input logic             done,
  input logic             byte_start
);
  logic [DIV_W:0]   hi_run;
  logic [DIV_W+1:0] cs_hi;
  logic [DIV_W+1:0] gap_min;

  assign gap_min = ((DIV_W+2)'(clk_div) + 1'b1) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      cs_hi  <= '1;
    end else begin
      hi_run <= spi_sck ? hi_run + 1'b1 : '0;
      if (!spi_cs_n) cs_hi <= '0;
      else if (cs_hi != '1) cs_hi <= cs_hi + 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R1
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R1
  AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sck) |-> (hi_run == ({1'b0, clk_div} + 1'b1))); // R2
  AST_BYTE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_start |-> !spi_cs_n); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R10
  AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n); // R11
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_hi >= gap_min)); // R11
endmodule

bind spi_mem_engine spi_mem_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_div    (clk_div),
  .spi_cs_n   (spi_cs_n),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi),
  .req_ready  (req_ready),
  .done       (done),
  .byte_start (byte_start)
);

// File: tb/tb_spi_mem_engine.sv
module tb_spi_mem_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_burst = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        done;
  logic        tx_valid;
  logic        tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        spi_sck;
  logic        spi_mosi;
  logic        spi_miso;
  logic        spi_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_engine dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_burst(req_burst),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] resp [64];
  logic [7:0] stx  [64];
  logic [7:0] mlog [64];
  logic [7:0] rlog [64];
  logic [7:0] sh = 8'h00;
  int  sl_bit = 0;
  int  rcount = 0, done_cnt = 0;
  int  sck_hi = 0, half_seen = 0, half_bad = 0;
  int  cs_run = 1000, gap_seen = 0, gap_bad = 0;
  int  stall_bad = 0, tx_ptr = 0;
  int  cur_div = 0;
  bit  tx_pend = 1'b0;
  logic pc = 1'b1, ps = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int hdr_of(int op);
    return (op == 1 || op == 2) ? 3 : 4;
  endfunction

  function automatic int frame_len(int op, int len);
    return (op == 2) ? 3 : hdr_of(op) + len;
  endfunction

  function automatic logic [7:0] exp_byte(int op, int addr, bit burst,
                                          logic [31:0] wd, int k);
    int h = hdr_of(op);
    if (op == 2) return (k == 0) ? wd[7:0] : 8'h00;
    if (k == 0) return 8'((addr >> 16) & 8'h3F) | ((op == 1) ? 8'h80 : 8'h00);
    if (k == 1) return 8'((addr >> 8) & 8'hFF);
    if (k == 2) return 8'(addr & 8'hFF);
    if (k < h) return 8'h00;
    if (op != 1) return 8'h00;
    if (burst) return stx[k-h];
    return 8'((wd >> (8*(k-h))) & 32'hFF);
  endfunction

  function automatic logic [31:0] exp_rd(int len);
    logic [31:0] v = '0;
    for (int j = 0; j < len; j++) v = v | (32'(resp[4+j]) << (8*j));
    return v;
  endfunction

  // peripheral model: mode 0, MSB first
  initial begin
    spi_miso = 1'b0;
    forever begin
      @(spi_sck or spi_cs_n);
      if (pc && !spi_cs_n) begin
        sl_bit   = 0;
        spi_miso = resp[0][7];
      end
      if (!spi_cs_n) begin
        if (!ps && spi_sck) begin
          sh = {sh[6:0], spi_mosi};
          sl_bit++;
          if (sl_bit % 8 == 0 && sl_bit/8 <= 64) mlog[sl_bit/8-1] = sh;
        end else if (ps && !spi_sck) begin
          spi_miso = resp[(sl_bit/8) % 64][7 - (sl_bit % 8)];
        end
      end
      pc = spi_cs_n;
      ps = spi_sck;
    end
  end

  // burst write byte source with random stalls
  initial begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (tx_pend) tx_ptr++;
      if (tx_ready && !tx_valid && !(spi_sck == 1'b0 && spi_cs_n == 1'b0)) stall_bad++;
      tx_valid = ($urandom % 4) != 0;
      tx_data  = stx[tx_ptr % 64];
      tx_pend  = tx_valid && tx_ready;
    end
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      if (rcount < 64) rlog[rcount] = rx_data;
      rcount++;
    end
    if (done) done_cnt++;
    if (spi_sck) sck_hi++;
    else if (sck_hi != 0) begin
      half_seen++;
      if (sck_hi != cur_div + 1) half_bad++;
      sck_hi = 0;
    end
    if (spi_cs_n) cs_run++;
    else if (cs_run != 0) begin
      gap_seen++;
      if (cs_run < 2*(cur_div + 1)) gap_bad++;
      cs_run = 0;
    end
  end

  task automatic run_txn(input int op, input int addr, input int len, input bit burst,
                         input logic [31:0] wd, input int div);
    int fl = frame_len(op, len);
    string tag;
    while (!req_ready) @(negedge clk);
    if (div != cur_div) begin
      clk_div = 8'(div);
      cur_div = div;
      repeat (2*(div+1) + 1) @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      resp[i] = 8'($urandom);
      stx[i]  = 8'($urandom);
    end
    done_cnt = 0; rcount = 0; half_seen = 0; half_bad = 0;
    gap_seen = 0; gap_bad = 0; stall_bad = 0; tx_ptr = 0;
    req_op = 2'(op); req_addr = 22'(addr); req_len = 8'(len);
    req_burst = burst; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    while (!req_ready) @(negedge clk);

    tag = (op == 2) ? "R7" : (op == 1) ? (burst ? "R8" : "R3 R5") : "R4";
    chk(sl_bit == 8*fl, "R10", "frame bits", sl_bit, 8*fl);
    begin
      int bad_k = -1;
      for (int k = 0; k < fl && k < 64; k++)
        if (bad_k < 0 && mlog[k] !== exp_byte(op, addr, burst, wd, k)) bad_k = k;
      if (bad_k < 0) chk(1'b1, tag, "mosi bytes", 0, 0);
      else chk(1'b0, tag, $sformatf("mosi byte %0d", bad_k),
               mlog[bad_k], exp_byte(op, addr, burst, wd, bad_k));
    end
    if (op == 0 && !burst)
      chk(rd_data === exp_rd(len), "R6 R1", "rd_data", rd_data, exp_rd(len));
    if (op == 0 && burst) begin
      int bad_j = -1;
      for (int j = 0; j < len && j < 64; j++)
        if (bad_j < 0 && rlog[j] !== resp[4+j]) bad_j = j;
      chk(rcount == len, "R9", "rx byte count", rcount, len);
      if (bad_j >= 0) chk(1'b0, "R9", "rx byte", rlog[bad_j], resp[4+bad_j]);
    end
    if (op == 1 && burst) begin
      chk(tx_ptr == len, "R8", "stream bytes taken", tx_ptr, len);
      chk(stall_bad == 0, "R8", "sck or cs moved during stall", stall_bad, 0);
    end
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(half_bad == 0 && half_seen == 8*fl, "R2", "sck high phases",
        half_bad, 0);
    if (gap_seen > 0) chk(gap_bad == 0, "R11", "cs high gap", gap_bad, 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "reset link state",
        {spi_cs_n, spi_sck}, 2'b10);
    chk(req_ready === 1'b1 && done === 1'b0 && rx_valid === 1'b0, "R11", "reset handshake",
        {req_ready, done, rx_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    run_txn(1, 22'h3FFFFF, 4, 1'b0, 32'hA1B2C3D4, 0);   // R3 R5 flag with all-ones address
    run_txn(1, 22'h3FFFFF, 2, 1'b0, 32'h00005A6B, 0);   // R11 back-to-back gap
    run_txn(0, 22'h000000, 2, 1'b0, 32'h0, 1);          // R4 R6 zero address
    run_txn(0, 22'h123456, 4, 1'b0, 32'h0, 1);          // R6 full word
    run_txn(0, 22'h2C0F11, 1, 1'b0, 32'h0, 1);          // R6 single byte, upper zero
    run_txn(2, 22'h000000, 0, 1'b0, 32'h00000068, 0);   // R7 host command
    run_txn(1, 22'h2ABCDE, 6, 1'b1, 32'h0, 2);          // R8 burst write with stalls
    run_txn(0, 22'h000100, 5, 1'b1, 32'h0, 2);          // R9 burst read
    for (int t = 0; t < 30; t++) begin
      int op    = int'($urandom % 3);
      bit burst = (op != 2) && ($urandom % 3 == 0);
      int len   = burst ? 1 + int'($urandom % 12) : 1 + int'($urandom % 4);
      run_txn(op, int'($urandom & 32'h3FFFFF), len, burst, $urandom, int'($urandom % 4));
    end
    summary();
    $finish;
  end
endmodule